// File: doc/BRIEF.md
# Multi-Channel Wakeup Event Detector

The block watches a set of candidate wakeup lines and keeps one sticky flag per wakeup channel. Each channel has three settings: an enable, a polarity and a two-bit source select. The source select picks one of four candidate lines for that channel. The external lines pass through a two-flop synchroniser. A channel's flag is set when its selected synchronised line changes to the active level. Software clears flags by writing ones to a write-one-to-clear register. Hardware clears a flag while its channel is disabled.

The upper channels (5, 6 and 7 by default) can instead select an internal pending source, using select code 3. In that mode the flag tracks the internal pending bit, and a software clear has no effect on it.

A registered wakeup request is the OR of the flags of the enabled channels. The block that sequences power consumes this request.

Top module: `wkup_detect`

## Requirements
- R1: After reset, all flags, the wakeup request and the enable, polarity and select registers read 0. Register map by word address: 0 enable (bit c = channel c), 1 polarity (bit c), 2 select (bits 2c+1:2c = channel c), 3 clear (write-one-to-clear, bit c, reads 0).
- R2: With polarity 0, a low-to-high change on the selected line sets the channel flag on the third rising clock edge after the line changes.
- R3: With polarity 1, a high-to-low change on the selected line sets the flag with the same latency as R2.
- R4: Channel c with select s watches `wake_lines_i[c*4+s]`. Changes on the channel's other candidate lines do not set its flag.
- R5: A write to the polarity or select register leaves unchanged the fields of channels whose enable bit is 1. The fields of disabled channels are updated.
- R6: In external mode, writing 1 to a channel's bit in the clear register clears its flag at the write edge.
- R7: A flag is cleared on the first clock edge after its channel's enable bit reads 0.
- R8: For a channel of index 5 or above with select 3, the flag follows `int_pend_i[c-5]` one edge later, and the clear register does not affect it.
- R9: If a wakeup event and a software clear of the same channel fall in the same cycle, the flag ends up set.
- R10: `wake_req_o` equals the OR of (flags AND enables) of the previous cycle, one edge after the flags.
- R11: A line held at the active level does not set the flag again after it has been cleared; setting it again takes a new transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_lines_i | input | 32 | Candidate lines, four per channel, asynchronous |
| int_pend_i | input | 3 | Internal pending sources for channels 5 to 7 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| flags_o | output | 8 | Sticky wakeup flags |
| wake_req_o | output | 1 | Registered wakeup request |

## Verification
The timing of each result is fixed:
- An external line change reaches its flag on the third rising edge: two synchroniser stages, then the flag register.
- The request follows one edge after the flag.
- Internal pending changes, clears and disables act on the first edge after their stimulus.

Each driver step advances the exact number of edges for the result it tests before it queues the expected value. The monitor compares every queued value at the following falling edge, half a cycle after the update. The set-versus-clear case places the clear write on the very edge at which the event is registered.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  parameter int unsigned NUM_CH    = 8;
  parameter int unsigned NUM_SRC   = 4;
  parameter int unsigned SEL_W     = $clog2(NUM_SRC);
  parameter int unsigned INT_FIRST = 5;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned SYNC_LEN  = 2;

  typedef enum logic [1:0] {
    ADDR_EN  = 2'd0,
    ADDR_POL = 2'd1,
    ADDR_SEL = 2'd2,
    ADDR_CLR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;

  // R2: the previous-value tap lags the synchronised output by one edge
  a_r2_prev_lags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prev_o == $past(sync_o));
endmodule

// File: rtl/wkup_cfg_regs.sv
module wkup_cfg_regs
  import wkup_pkg::*;
#(
  parameter int unsigned N_CH  = NUM_CH,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned SELV = N_CH * SW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] pol_o,
  output logic [SELV-1:0] sel_o,
  output logic [N_CH-1:0] clr_o
);
  logic [N_CH-1:0] en_q, pol_q;
  logic [SELV-1:0] sel_q;
  logic wr_en, wr_pol, wr_sel, wr_clr;

  assign wr_en  = we_i && (addr_i == ADDR_EN);
  assign wr_pol = we_i && (addr_i == ADDR_POL);
  assign wr_sel = we_i && (addr_i == ADDR_SEL);
  assign wr_clr = we_i && (addr_i == ADDR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (wr_en)  en_q <= wdata_i[N_CH-1:0];
  end

  // polarity and select fields are frozen while their channel is enabled
  for (genvar c = 0; c < N_CH; c++) begin : g_field
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pol_q[c]          <= 1'b0;
        sel_q[c*SW +: SW] <= '0;
      end else begin
        if (wr_pol && !en_q[c]) pol_q[c]          <= wdata_i[c];
        if (wr_sel && !en_q[c]) sel_q[c*SW +: SW] <= wdata_i[c*SW +: SW];
      end
    end
  end

  assign clr_o = wr_clr ? wdata_i[N_CH-1:0] : '0;

  always_comb begin
    unique case (addr_i)
      ADDR_EN:  rdata_o = DW'(en_q);
      ADDR_POL: rdata_o = DW'(pol_q);
      ADDR_SEL: rdata_o = DW'(sel_q);
      default:  rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign sel_o = sel_q;

  a_r5_pol_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pol_q ^ $past(pol_q)) & $past(en_q)) == '0);
  a_r5_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel |=> sel_q == $past(sel_q));
endmodule

// File: rtl/wkup_channel.sv
module wkup_channel
  import wkup_pkg::*;
#(
  parameter int unsigned N_SRC   = NUM_SRC,
  parameter int unsigned SW      = SEL_W,
  parameter bit          HAS_INT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] cur_i,
  input  logic [N_SRC-1:0] prv_i,
  input  logic [SW-1:0]    sel_i,
  input  logic             pol_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             int_pend_i,
  output logic             flag_o
);
  logic act_now, act_prev, evt, int_mode, flag_q;

  assign act_now  = cur_i[sel_i] ^ pol_i;
  assign act_prev = prv_i[sel_i] ^ pol_i;
  assign evt      = act_now && !act_prev;
  assign int_mode = HAS_INT && (sel_i == SW'(N_SRC-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (!en_i)    flag_q <= 1'b0;
    else if (int_mode) flag_q <= int_pend_i;
    else if (evt)      flag_q <= 1'b1;  // set wins over clear
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !flag_o);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !int_mode && evt && clr_i) |=> flag_o);
  a_r8_follows_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && int_mode) |=> flag_o == $past(int_pend_i));
  a_r11_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !int_mode && !evt) |=> !flag_o);
endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
  import wkup_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned INT_LO = INT_FIRST,
  parameter int unsigned DW     = DATA_W,
  localparam int unsigned SW    = $clog2(N_SRC),
  localparam int unsigned N_LN  = N_CH * N_SRC,
  localparam int unsigned N_INT = N_CH - INT_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LN-1:0]  wake_lines_i,
  input  logic [N_INT-1:0] int_pend_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic [N_CH-1:0]  flags_o,
  output logic             wake_req_o
);
  logic [N_LN-1:0]    ln_sync, ln_prev;
  logic [N_CH-1:0]    en, pol, clr, flags;
  logic [N_CH*SW-1:0] sel;
  logic               req_q;

  wkup_sync #(.WIDTH(N_LN), .STAGES(SYNC_LEN)) i_sync (
    .clk_i, .rst_ni, .d_i(wake_lines_i), .sync_o(ln_sync), .prev_o(ln_prev)
  );

  wkup_cfg_regs #(.N_CH(N_CH), .SW(SW), .DW(DW)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .en_o(en), .pol_o(pol), .sel_o(sel), .clr_o(clr)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    if (c >= INT_LO) begin : g_int
      wkup_channel #(.N_SRC(N_SRC), .SW(SW), .HAS_INT(1'b1)) i_ch (
        .clk_i, .rst_ni,
        .cur_i(ln_sync[c*N_SRC +: N_SRC]), .prv_i(ln_prev[c*N_SRC +: N_SRC]),
        .sel_i(sel[c*SW +: SW]), .pol_i(pol[c]), .en_i(en[c]), .clr_i(clr[c]),
        .int_pend_i(int_pend_i[c-INT_LO]), .flag_o(flags[c])
      );
    end else begin : g_ext
      wkup_channel #(.N_SRC(N_SRC), .SW(SW), .HAS_INT(1'b0)) i_ch (
        .clk_i, .rst_ni,
        .cur_i(ln_sync[c*N_SRC +: N_SRC]), .prv_i(ln_prev[c*N_SRC +: N_SRC]),
        .sel_i(sel[c*SW +: SW]), .pol_i(pol[c]), .en_i(en[c]), .clr_i(clr[c]),
        .int_pend_i(1'b0), .flag_o(flags[c])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= |(flags & en);
  end

  assign flags_o    = flags;
  assign wake_req_o = req_q;

  a_r10_req_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> $past(|flags_o));
  a_r10_flag_raises_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_o & en)) |=> wake_req_o);
endmodule

// File: tb/test_wkup_detect.sv
module test_wkup_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wake_lines_i = '0;
  logic [2:0]  int_pend_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  flags_o;
  logic        wake_req_o;

  always #4 clk_i = ~clk_i;

  wkup_detect i_wkup_detect (.*);

  typedef struct {
    int          kind;   // 0 flags, 1 request, 2 read data
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic push(int kind, logic [31:0] e, string tag);
    exp_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick(1);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [31:0] e, string tag);
    reg_addr_i = a;
    push(2, e, tag);
    tick(1);
  endtask

  // monitor: compares queued expectations half a cycle after the update
  always @(negedge clk_i) begin
    exp_t        it;
    logic [31:0] act;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = 32'(flags_o);
        1:       act = 32'(wake_req_o);
        default: act = reg_rdata_o;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    push(0, 32'h0, "R1 flags");
    push(1, 32'h0, "R1 req");
    rd_chk(2'd0, 32'h0, "R1 enable");
    rd_chk(2'd1, 32'h0, "R1 polarity");
    rd_chk(2'd2, 32'h0, "R1 select");
    rd_chk(2'd3, 32'h0, "R1 clear reads zero");

    // R2 rising edge on channel 0, source 0
    wr(2'd0, 32'h01);
    wake_lines_i[0] = 1'b1;
    tick(2);
    push(0, 32'h00, "R2 not before third edge");
    tick(1);
    push(0, 32'h01, "R2 rising sets flag");
    push(1, 32'h0, "R10 req lags flag");
    tick(1);
    push(1, 32'h1, "R10 req asserted");
    tick(1);

    // R6 software clear, R11 held level gives no new event
    wr(2'd3, 32'h01);
    push(0, 32'h00, "R6 clear at write edge");
    tick(4);
    push(0, 32'h00, "R11 held level no re-set");
    push(1, 32'h0, "R10 req drops");
    tick(1);

    // R3 falling edge on channel 1, source 2 (line 6), R4 other lines ignored
    wr(2'd1, 32'h02);
    wr(2'd2, 32'h08);
    wake_lines_i[6] = 1'b1;
    tick(3);
    wr(2'd0, 32'h03);
    wake_lines_i[4] = 1'b1;
    tick(2);
    wake_lines_i[4] = 1'b0;
    wake_lines_i[5] = 1'b1;
    tick(4);
    push(0, 32'h00, "R4 unselected lines ignored");
    tick(1);
    wake_lines_i[6] = 1'b0;
    tick(3);
    push(0, 32'h02, "R3 falling sets flag");

    // R5 writes to enabled channel fields ignored
    wr(2'd1, 32'h00);
    wr(2'd2, 32'h00);
    rd_chk(2'd1, 32'h02, "R5 polarity frozen");
    rd_chk(2'd2, 32'h08, "R5 select frozen");

    // R7 disable clears the flag one edge later
    wr(2'd0, 32'h01);
    tick(1);
    push(0, 32'h00, "R7 disable clears flag");
    tick(1);

    // R9 set and clear in the same cycle
    wake_lines_i[0] = 1'b0;
    tick(3);
    wake_lines_i[0] = 1'b1;
    tick(2);
    wr(2'd3, 32'h01);
    push(0, 32'h01, "R9 set wins over clear");
    tick(1);
    wr(2'd3, 32'h01);
    push(0, 32'h00, "R6 clear after R9");
    tick(1);

    // R8 internal source on channel 5
    wr(2'd2, 32'h0C00);
    rd_chk(2'd2, 32'h0C00, "R5 disabled fields update");
    wr(2'd0, 32'h21);
    int_pend_i = 3'b001;
    tick(1);
    push(0, 32'h20, "R8 flag follows pending");
    tick(1);
    push(1, 32'h1, "R10 req from internal flag");
    wr(2'd3, 32'h20);
    push(0, 32'h20, "R8 clear register no effect");
    tick(1);
    int_pend_i = 3'b000;
    tick(1);
    push(0, 32'h00, "R8 flag drops with pending");
    tick(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule